// File: doc/BRIEF.md
# Toggling Phase-Frequency Detector

This block compares two streams of one-cycle edge pulses, one from the divided reference and one from the divided oscillator, and drives a single bit toward an external loop filter. A reference pulse drives the output high and an oscillator pulse drives it low. When the loop is locked, the two pulse streams alternate half a comparison period apart, so the output is a square wave with a 50% duty cycle. The two toggling events are then never coincident. When the frequencies differ, one source delivers several pulses in a row, so the output sits at one level and pushes the oscillator in the correct direction. This lets the loop acquire lock from any starting frequency.

Everything is sampled on a single fast clock, typically far above the 1 MHz comparison rate. A lock indicator reports when the pulses have alternated strictly for a programmable number of comparison cycles.

Top module: `toggle_pfd`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, pfd_out is 0 and locked is 0.
- R2: A cycle with ref_evt=1 and vco_evt=0 makes pfd_out 1 after that clock edge.
- R3: A cycle with vco_evt=1 and ref_evt=0 makes pfd_out 0 after that clock edge.
- R4: Consecutive pulses from the same source keep pfd_out at the level that source sets, so a frequency error gives a saturated level.
- R5: A cycle with both ref_evt and vco_evt at 1 leaves pfd_out unchanged.
- R6: A lone reference pulse that directly follows a lone oscillator pulse, with no other event between them, advances an alternation count. locked is 1 once that count reaches LOCK_CYCLES (default 16). The count saturates there.
- R7: Two lone oscillator pulses in a row, or a simultaneous pulse pair, clear the alternation count and drop locked. A reference pulse that does not follow an oscillator pulse also clears the count.
- R8: A cycle with no pulse leaves pfd_out and locked unchanged.
- R9: With lone pulses spaced evenly, the oscillator pulse half a period after the reference pulse, pfd_out is high for exactly half of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_evt | input | 1 | One-cycle pulse from the divided reference |
| vco_evt | input | 1 | One-cycle pulse from the divided oscillator |
| pfd_out | output | 1 | Detector output to the loop filter |
| locked | output | 1 | Strict alternation seen for LOCK_CYCLES comparisons |

## Verification
The bench drives repeated pulses from the same source. A detector that toggles instead of setting and clearing would flip the output on the second pulse and lose frequency discrimination. Simultaneous pulses are applied from both output levels, which catches a design that lets one input win.

The lock count is probed one comparison before and exactly at the threshold, which exposes an off-by-one. The bench also breaks the lock with a doubled oscillator pulse, with a coincident pair and with reset. A design that failed to clear its count on any of these would keep reporting lock. A duty-cycle measurement in lock catches any extra cycle of delay on one of the two edges.

// File: rtl/toggle_pfd.sv
module toggle_pfd #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_evt,
  input  logic vco_evt,
  output logic pfd_out,
  output logic locked
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_MAX = CW'(LOCK_CYCLES);

  typedef enum logic [1:0] {SRC_NONE, SRC_REF, SRC_VCO} src_t;

  src_t          last_src;
  logic [CW-1:0] streak;

  wire ref_only = ref_evt & ~vco_evt;
  wire vco_only = vco_evt & ~ref_evt;
  wire clash    = ref_evt & vco_evt;

  wire [CW-1:0] streak_inc = (streak == LOCK_MAX) ? streak : streak + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfd_out  <= 1'b0;
      last_src <= SRC_NONE;
      streak   <= '0;
    end else if (clash) begin
      last_src <= SRC_NONE;
      streak   <= '0;
    end else if (ref_only) begin
      pfd_out  <= 1'b1;
      last_src <= SRC_REF;
      streak   <= (last_src == SRC_VCO) ? streak_inc : '0;
    end else if (vco_only) begin
      pfd_out  <= 1'b0;
      last_src <= SRC_VCO;
      if (last_src == SRC_VCO) streak <= '0;
    end
  end

  assign locked = (streak == LOCK_MAX);

endmodule

// File: rtl/toggle_pfd_chk.sv
module toggle_pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_evt,
  input logic vco_evt,
  input logic pfd_out,
  input logic locked
);

  // R2
  ref_sets_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_evt && !vco_evt) |=> pfd_out);

  // R3
  vco_clears_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_evt && !ref_evt) |=> !pfd_out);

  // R5
  clash_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_evt && ref_evt) |=> $stable(pfd_out));

  // R7
  clash_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_evt && ref_evt) |=> !locked);

  // R8
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_evt && !vco_evt) |=> ($stable(pfd_out) && $stable(locked)));

  // R6
  lock_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_evt && !vco_evt));

endmodule

bind toggle_pfd toggle_pfd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .vco_evt(vco_evt),
  .pfd_out(pfd_out), .locked(locked)
);

// File: tb/toggle_pfd_tb.sv
`timescale 1ns/1ps
module toggle_pfd_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_evt = 1'b0;
  logic vco_evt = 1'b0;
  logic pfd_out;
  logic locked;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  toggle_pfd #(.LOCK_CYCLES(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .vco_evt(vco_evt),
    .pfd_out(pfd_out), .locked(locked)
  );

  // {ref_evt, vco_evt, expected pfd_out}
  localparam logic [2:0] VEC [12] = '{
    3'b00_0, 3'b10_1, 3'b00_1, 3'b10_1, 3'b01_0, 3'b01_0,
    3'b11_0, 3'b10_1, 3'b11_1, 3'b00_1, 3'b01_0, 3'b00_0
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic r, input logic v);
    @(negedge clk);
    ref_evt = r;
    vco_evt = v;
    @(posedge clk);
    #1;
    ref_evt = 1'b0;
    vco_evt = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic build_lock();
    for (int k = 0; k <= 16; k++) begin
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b0);
      pulse(1'b0, 1'b1);
      pulse(1'b0, 1'b0);
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out in reset", pfd_out, 1'b0);
    check("R1 lock in reset", locked, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 out after reset", pfd_out, 1'b0);
    check("R1 lock after reset", locked, 1'b0);

    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i][2], VEC[i][1]);
      check("vector table R2 R3 R4 R5 R8", pfd_out, VEC[i][0]);
    end

    do_reset();
    for (int k = 0; k <= 16; k++) begin
      pulse(1'b1, 1'b0);
      if (k == 15) check("R6 not yet locked at 15", locked, 1'b0);
      if (k == 16) check("R6 locked at 16", locked, 1'b1);
      pulse(1'b0, 1'b0);
      pulse(1'b0, 1'b1);
      pulse(1'b0, 1'b0);
    end
    check("R6 lock holds", locked, 1'b1);

    begin
      int highs = 0;
      for (int c = 0; c < 8; c++) begin
        pulse(c == 0, c == 4);
        if (pfd_out) highs++;
      end
      check("R9 duty half", highs == 4, 1'b1);
    end
    check("R6 lock kept in even run", locked, 1'b1);

    pulse(1'b0, 1'b1);
    check("R7 double vco drops lock", locked, 1'b0);
    check("R4 double vco low", pfd_out, 1'b0);

    build_lock();
    check("R6 relock", locked, 1'b1);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    check("R7 clash drops lock", locked, 1'b0);
    check("R5 clash keeps high", pfd_out, 1'b1);

    build_lock();
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check("R7 double ref drops lock", locked, 1'b0);
    check("R4 double ref high", pfd_out, 1'b1);

    build_lock();
    pulse(1'b1, 1'b0);
    repeat (10) pulse(1'b0, 1'b0);
    check("R8 idle keeps lock", locked, 1'b1);
    check("R8 idle keeps out", pfd_out, 1'b1);
    do_reset();
    #1;
    check("R1 reset clears lock", locked, 1'b0);
    check("R1 reset clears out", pfd_out, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule